// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block times the start-up and the refresh of an asynchronous DRAM for the command sequencer that drives the memory strobes. After reset it keeps every access blocked for a fixed power-up pause. It then asks the sequencer for a run of eight warm-up strobe cycles, and it raises `init_done` once all of them are acknowledged. The sequencer may use either RAS-only or CAS-before-RAS cycles for the warm-up.

In normal running the block issues one CAS-before-RAS refresh request per interval. The interval is derived from the clock frequency, so that 1,024 refreshes fit in every 16 ms window. The interval is `floor(CLK_HZ*16/1000/1024)` clock cycles, which is 781 at 50 MHz. No row address is produced because the memory's own counter picks the row. Intervals that pass while the sequencer is busy are queued in a backlog of up to eight. If a ninth comes due, the refresh deadline is taken as missed: the block flags an error, withdraws `init_done`, and reruns the warm-up.

The request side is a valid/ready pair. `refresh_req` acts as valid and `refresh_ack` acts as ready. A transfer takes place on any rising clock edge where both are high. The sequencer applies back-pressure by leaving `refresh_ack` low, and the request then stays up. The request is only shown while `seq_idle` is high, so a busy sequencer holds it off without losing it.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `init_done`, `refresh_req` and `overrun_err` are all 0.
- R2: `refresh_req` stays 0 for the power-up pause, `PAUSE_US` microseconds (10,000 cycles at the defaults). It first rises exactly that many clock edges after reset is released, provided `seq_idle` is 1.
- R3: During warm-up, `refresh_kind` is 0 and the request is held until eight transfers have occurred. `init_done` rises on the eighth transfer, and `refresh_req` is 0 immediately afterwards.
- R4: `refresh_req` is 1 only while `seq_idle` is 1. Once shown, it stays 1 until a transfer occurs.
- R5: After `init_done` rises, the first periodic request, with `refresh_kind` = 1, appears exactly `floor(CLK_HZ/1000*16/1024)` clock edges later. Requests then recur at that period.
- R6: Intervals that elapse without a transfer accumulate, up to eight. Each one needs its own transfer before `refresh_req` falls.
- R7: An interval that elapses while eight refreshes are outstanding sets `overrun_err` to 1, clears `init_done` and restarts the warm-up with `refresh_kind` = 0.
- R8: After an overrun, eight further warm-up transfers set `init_done` to 1 again and clear `overrun_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_idle | input | 1 | The sequencer can accept a refresh now |
| refresh_ack | input | 1 | Ready: takes the current request |
| init_done | output | 1 | Pause and warm-up complete; traffic allowed |
| refresh_req | output | 1 | Valid: a refresh cycle is wanted |
| refresh_kind | output | 1 | 0 = warm-up strobe cycle, 1 = periodic CAS-before-RAS refresh |
| overrun_err | output | 1 | Refresh deadline missed; held until warm-up completes again |

## Verification
The bench runs the block through several input patterns, and each one separates one behaviour from the others:
- **Idle sequencer throughout.** This measures the exact pause length and the exact refresh period, so an off-by-one in either timer shows up.
- **Sequencer busy during warm-up.** This shows whether the request is gated by `seq_idle` rather than dropped.
- **Busy for several intervals, then acknowledged in a burst.** This counts the queued refreshes, so a backlog that saturates or loses an interval stands out.
- **Busy long enough for a ninth interval.** This sets a premature overrun apart from a missing one, and then confirms that the warm-up reruns to completion.

A scoreboard checks the `refresh_kind` of every transfer.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WARM  = 2'd1,
    PH_RUN   = 2'd2
  } sched_phase_e;

  localparam logic KIND_WARM     = 1'b0;
  localparam logic KIND_PERIODIC = 1'b1;
endpackage

// File: rtl/sched_cycle_timer.sv
module sched_cycle_timer #(
  parameter int LIMIT = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sched_event_counter.sv
module sched_event_counter #(
  parameter int MAX = 8,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         over
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic at_top;
  assign at_top = (count == TOP);
  assign over   = inc && !dec && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)                       count <= '0;
    else if (inc && !dec && !at_top)           count <= count + 1'b1;
    else if (dec && !inc && count != '0)       count <= count - 1'b1;
  end
endmodule

// File: rtl/sched_phase_ctrl.sv
module sched_phase_ctrl
  import dram_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pause_tick,
  input  logic         warm_done,
  input  logic         overflow,
  output sched_phase_e phase,
  output logic         overrun_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_PAUSE;
      overrun_err <= 1'b0;
    end else begin
      unique case (phase)
        PH_PAUSE: if (pause_tick) phase <= PH_WARM;
        PH_WARM: if (warm_done) begin
          phase       <= PH_RUN;
          overrun_err <= 1'b0;
        end
        PH_RUN: if (overflow) begin
          phase       <= PH_WARM;
          overrun_err <= 1'b1;
        end
        default: phase <= PH_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_sched_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int PAUSE_US      = 200,
  parameter int WINDOW_MS     = 16,
  parameter int ROWS          = 1024,
  parameter int WARM_CYCLES   = 8,
  parameter int BACKLOG_MAX   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_idle,
  input  logic refresh_ack,
  output logic init_done,
  output logic refresh_req,
  output logic refresh_kind,
  output logic overrun_err
);
  localparam int KHZ       = CLK_HZ / 1000;
  localparam int PAUSE_CYC = KHZ * PAUSE_US / 1000;
  localparam int INTV_CYC  = KHZ * WINDOW_MS / ROWS;
  localparam int BW        = $clog2(BACKLOG_MAX + 1);
  localparam int WW        = $clog2(WARM_CYCLES + 1);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARM_CYCLES - 1);

  sched_phase_e  phase;
  logic          pause_tick, intv_tick, xfer;
  logic          in_warm, in_run, warm_done, overflow;
  logic [BW-1:0] backlog;
  logic [WW-1:0] warm_cnt;
  logic          warm_over_unused;

  assign in_warm = (phase == PH_WARM);
  assign in_run  = (phase == PH_RUN);

  generate
    if (PAUSE_CYC > 0) begin : g_pause
      sched_cycle_timer #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk(clk), .rst_n(rst_n), .run(phase == PH_PAUSE), .tick(pause_tick)
      );
    end else begin : g_nopause
      assign pause_tick = (phase == PH_PAUSE);
    end
  endgenerate

  sched_cycle_timer #(.LIMIT(INTV_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .run(in_run), .tick(intv_tick)
  );

  sched_event_counter #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .clear(!in_run),
    .inc(intv_tick), .dec(xfer && in_run),
    .count(backlog), .over(overflow)
  );

  sched_event_counter #(.MAX(WARM_CYCLES)) u_warm (
    .clk(clk), .rst_n(rst_n), .clear(!in_warm),
    .inc(xfer && in_warm), .dec(1'b0),
    .count(warm_cnt), .over(warm_over_unused)
  );

  assign warm_done = in_warm && xfer && (warm_cnt == WARM_LAST);

  sched_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .pause_tick(pause_tick),
    .warm_done(warm_done), .overflow(overflow),
    .phase(phase), .overrun_err(overrun_err)
  );

  assign refresh_req  = seq_idle && (in_warm || (in_run && backlog != '0));
  assign xfer         = refresh_req && refresh_ack;
  assign refresh_kind = in_run ? KIND_PERIODIC : KIND_WARM;
  assign init_done    = in_run;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic seq_idle,
  input logic refresh_ack,
  input logic init_done,
  input logic refresh_req,
  input logic refresh_kind,
  input logic overrun_err
);
  // R4
  req_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> seq_idle);

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(refresh_req) && !$past(refresh_ack) && seq_idle) |-> refresh_req);

  // R3
  init_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> ($past(refresh_req) && $past(refresh_ack) && !refresh_req));

  // R7
  overrun_drops_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> (!init_done && $past(init_done)));

  // R8
  err_clears_with_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun_err) |-> $rose(init_done));

  // R3
  warm_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !init_done) |-> (refresh_kind == 1'b0));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk u_chk (.*);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int PAUSE = 10000;
  localparam int INTV  = 781;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_idle = 1'b1;
  logic refresh_ack = 1'b0;
  logic init_done, refresh_req, refresh_kind, overrun_err;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int t0, c0;
  bit done = 1'b0;
  logic exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .refresh_ack(refresh_ack),
    .init_done(init_done), .refresh_req(refresh_req),
    .refresh_kind(refresh_kind), .overrun_err(overrun_err)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive_idle(input logic v);
    @(posedge clk); #5 seq_idle = v;
  endtask

  // driver: one ready pulse, expected transfer kind pushed to the scoreboard
  task automatic ack_one(input logic kind);
    exp_q.push_back(kind);
    @(posedge clk); #5 refresh_ack = 1'b1;
    @(posedge clk); #5 refresh_ack = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: every transfer compared against the queue
  always @(negedge clk) begin
    if (rst_n && refresh_req && refresh_ack) begin
      if (exp_q.size() == 0) check("R4 unexpected transfer", 1, 0);
      else check("R3/R5 transfer kind", int'(refresh_kind), int'(exp_q.pop_front()));
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 init_done in reset", int'(init_done), 0);
    check("R1 refresh_req in reset", int'(refresh_req), 0);
    check("R1 overrun_err in reset", int'(overrun_err), 0);

    @(posedge clk); #5 rst_n = 1'b1; c0 = cyc;
    @(negedge clk);
    check("R1 outputs after release", int'(init_done | refresh_req | overrun_err), 0);

    // R2 pause length
    wait_until(c0 + PAUSE - 1);
    check("R2 no request inside pause", int'(refresh_req), 0);
    while (!refresh_req) @(negedge clk);
    check("R2 pause length", cyc - c0, PAUSE);
    check("R3 warm kind", int'(refresh_kind), 0);

    // R4 busy sequencer hides the request
    drive_idle(1'b0);
    @(negedge clk);
    check("R4 request gated by busy", int'(refresh_req), 0);
    drive_idle(1'b1);
    @(negedge clk);
    check("R4 request back when idle", int'(refresh_req), 1);

    // R3 eight warm-up transfers
    for (int i = 0; i < 7; i++) ack_one(1'b0);
    @(negedge clk);
    check("R3 not done after seven", int'(init_done), 0);
    check("R3 still requesting", int'(refresh_req), 1);
    ack_one(1'b0);
    t0 = cyc;
    @(negedge clk);
    check("R3 done after eighth", int'(init_done), 1);
    check("R3 request drops", int'(refresh_req), 0);

    // R5 periodic interval
    while (!refresh_req) @(negedge clk);
    check("R5 first interval", cyc - t0, INTV);
    check("R5 periodic kind", int'(refresh_kind), 1);
    repeat (50) @(negedge clk);
    check("R4 held without ack", int'(refresh_req), 1);
    ack_one(1'b1);
    @(negedge clk);
    check("R4 drops after transfer", int'(refresh_req), 0);

    // R6 backlog of three
    drive_idle(1'b0);
    wait_until(t0 + 4 * INTV + 10);
    drive_idle(1'b1);
    begin
      int n = 0;
      @(negedge clk);
      while (refresh_req && n < 12) begin
        ack_one(1'b1);
        n++;
        @(negedge clk);
      end
      check("R6 backlog transfers", n, 3);
    end

    // R7 overrun on the ninth outstanding interval
    drive_idle(1'b0);
    wait_until(t0 + 13 * INTV - 1);
    check("R7 still running before overrun", int'(init_done), 1);
    check("R7 no error before overrun", int'(overrun_err), 0);
    wait_until(t0 + 13 * INTV);
    check("R7 init_done withdrawn", int'(init_done), 0);
    check("R7 error raised", int'(overrun_err), 1);
    check("R4 busy hides warm request", int'(refresh_req), 0);
    drive_idle(1'b1);
    @(negedge clk);
    check("R7 warm-up request", int'(refresh_req), 1);
    check("R7 warm-up kind", int'(refresh_kind), 0);

    // R8 recovery
    for (int i = 0; i < 7; i++) ack_one(1'b0);
    @(negedge clk);
    check("R8 error held during rerun", int'(overrun_err), 1);
    check("R8 not done after seven", int'(init_done), 0);
    ack_one(1'b0);
    @(negedge clk);
    check("R8 init_done restored", int'(init_done), 1);
    check("R8 error cleared", int'(overrun_err), 0);
    check("R8 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule